// File: doc/BRIEF.md
# Write-Data Delay Split Register

This block is the per-byte-lane write-data delay register of a memory interface PHY. Software writes a total delay, counted in delay-line taps, as a single 32-bit word. The block waits a fixed settling interval and then splits that total into two parts. The first part is a count of whole unit-interval pipeline stages, presented on `pipe_cnt`. The second part is a residual tap count, shorter than one unit interval, which drives the fine delay line on `fine_taps`. The residual is also what the register returns on a read. The length of one unit interval in taps comes in on `ui_taps` and is captured at each write.

The hardware calibration and write-leveling engines may also load the field directly. A calibration load sets the field to one quarter of the clock period, given in taps. A leveling load sets it to the value the leveling engine found. A software write always takes precedence over either hardware source. The write port uses a valid/ready pair. `wr_ready` is held high at all times, so the block never applies back-pressure and every cycle with `wr_valid` high is an accepted write. The read data on `rd_data` is combinational and needs no handshake.

Top module: `wdly_split_reg`

## Requirements
- R1: After reset, `rd_data`, `pipe_cnt`, `fine_taps` and `busy` are all zero.
- R2: Bits 31:9 of `rd_data` always read zero, and the bits written there have no effect on any output.
- R3: `wr_ready` is always 1. A write accepted at a clock edge drives `busy` high for exactly 20 cycles. During that window `rd_data[8:0]` returns the raw value written, and `fine_taps` and `pipe_cnt` keep their previous values.
- R4: At the 20th rising edge after the write, `pipe_cnt` becomes floor(total / ui) and `fine_taps` becomes total − `pipe_cnt` × ui. Here ui is the value of `ui_taps` at the write.
- R5: After a conversion that did not saturate, `rd_data[8:0]` equals `fine_taps`, and this value is strictly less than ui.
- R6: A write made during the window restarts the 20-cycle countdown. Only the latest value is converted.
- R7: When ui is 0, the conversion gives `pipe_cnt` = 0 and `fine_taps` = the written total.
- R8: When the quotient exceeds 15, `pipe_cnt` saturates at 15 and `fine_taps` = total − 15 × ui.
- R9: A `cal_done` pulse sets `fine_taps` to `tck_taps` / 4 (bits 10:2) and `pipe_cnt` to 0 at the next edge. It also cancels any pending conversion, so `busy` drops.
- R10: A `wl_done` pulse sets `fine_taps` to `wl_taps` and `pipe_cnt` to 0, with the same cancelling effect. When sources coincide, a software write wins over `wl_done`, and `wl_done` wins over `cal_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Register write strobe |
| wr_ready | output | 1 | Write accept, always high |
| wr_data | input | 32 | Write word; bits 8:0 carry the total delay |
| rd_data | output | 32 | Read word |
| ui_taps | input | 9 | Unit-interval length in taps |
| cal_done | input | 1 | Calibration-complete pulse |
| tck_taps | input | 11 | Clock period in taps |
| wl_done | input | 1 | Write-leveling result pulse |
| wl_taps | input | 9 | Write-leveling delay in taps |
| busy | output | 1 | Conversion window active |
| pipe_cnt | output | 4 | Whole unit-interval pipeline stages |
| fine_taps | output | 9 | Residual tap count for the fine delay line |

## Verification
The hardest case to reach from the ports is a second write, or a hardware load, that lands inside an open settling window. Only the timing of `busy` and the later result can show that the first value was thrown away. The stimulus sets this up by placing a second write ten cycles into a window, then checking at the 19th and 20th edges after that second write. The saturated quotient is reached by pairing a small unit interval with a large total. The source-priority cases are driven by raising the write strobe and the hardware pulses in the same cycle.

// File: rtl/wds_pkg.sv
package wds_pkg;
  localparam int unsigned BUS_W_D  = 32;
  localparam int unsigned DLY_W_D  = 9;
  localparam int unsigned PIPE_W_D = 4;
  localparam int unsigned SETTLE_D = 20;

  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_SW   = 2'd1,
    LD_WL   = 2'd2,
    LD_CAL  = 2'd3
  } load_src_e;
endpackage

// File: rtl/wds_divider.sv
module wds_divider #(
  parameter int unsigned DW = 9,
  parameter int unsigned QW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic [QW-1:0] quo_sat
);
  localparam int unsigned SW = $clog2(DW + 1);
  localparam logic [SW-1:0] STEPS = SW'(DW);

  logic [DW-1:0] rem_q, quo_q, div_q;
  logic [SW-1:0] step_q;
  logic [DW:0]   shifted;
  logic          ge;
  logic [DW-1:0] nxt_rem, nxt_quo, quo_eff;

  always_comb begin
    shifted = {rem_q, quo_q[DW-1]};
    ge      = shifted >= {1'b0, div_q};
    nxt_rem = ge ? DW'(shifted - {1'b0, div_q}) : shifted[DW-1:0];
    nxt_quo = {quo_q[DW-2:0], ge};
    quo_eff = (div_q == '0) ? '0 : quo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      div_q  <= '0;
      step_q <= '0;
    end else if (start) begin
      rem_q  <= '0;
      quo_q  <= dividend;
      div_q  <= divisor;
      step_q <= (divisor == '0) ? '0 : STEPS;
    end else if (step_q != '0) begin
      rem_q  <= nxt_rem;
      quo_q  <= nxt_quo;
      step_q <= step_q - 1'b1;
    end
  end

  generate
    if (DW > QW) begin : g_sat
      always_comb quo_sat = (|quo_eff[DW-1:QW]) ? '1 : quo_eff[QW-1:0];
    end else begin : g_fit
      always_comb quo_sat = QW'(quo_eff);
    end
  endgenerate
endmodule

// File: rtl/wds_settle.sv
module wds_settle #(
  parameter int unsigned SETTLE = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  output logic busy,
  output logic commit
);
  localparam int unsigned CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LOADV = CW'(SETTLE);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (start)           cnt_q <= LOADV;
    else if (cancel)          cnt_q <= '0;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  always_comb begin
    busy   = cnt_q != '0;
    commit = (cnt_q == CW'(1)) && !start && !cancel;
  end
endmodule

// File: rtl/wds_field.sv
module wds_field
  import wds_pkg::*;
#(
  parameter int unsigned DW = 9,
  parameter int unsigned QW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  load_src_e     src,
  input  logic [DW-1:0] sw_val,
  input  logic [DW-1:0] ui_in,
  input  logic [DW-1:0] wl_val,
  input  logic [DW-1:0] cal_val,
  input  logic          commit,
  input  logic [QW-1:0] quo_sat,
  output logic [DW-1:0] raw,
  output logic [DW-1:0] ui_cap,
  output logic [DW-1:0] fine,
  output logic [QW-1:0] pipe
);
  localparam int unsigned PW = DW + QW;

  logic [PW-1:0] prod;
  logic [DW-1:0] resid;

  always_comb begin
    prod  = PW'(quo_sat) * PW'(ui_cap);
    resid = raw - prod[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw    <= '0;
      ui_cap <= '0;
      fine   <= '0;
      pipe   <= '0;
    end else begin
      unique case (src)
        LD_SW: begin
          raw    <= sw_val;
          ui_cap <= ui_in;
        end
        LD_WL: begin
          fine <= wl_val;
          pipe <= '0;
        end
        LD_CAL: begin
          fine <= cal_val;
          pipe <= '0;
        end
        default: begin
          if (commit) begin
            fine <= resid;
            pipe <= quo_sat;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/wdly_split_reg.sv
module wdly_split_reg
  import wds_pkg::*;
#(
  parameter int unsigned BUS_W  = BUS_W_D,
  parameter int unsigned DLY_W  = DLY_W_D,
  parameter int unsigned PIPE_W = PIPE_W_D,
  parameter int unsigned SETTLE = SETTLE_D
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [BUS_W-1:0]   wr_data,
  output logic [BUS_W-1:0]   rd_data,
  input  logic [DLY_W-1:0]   ui_taps,
  input  logic               cal_done,
  input  logic [DLY_W+1:0]   tck_taps,
  input  logic               wl_done,
  input  logic [DLY_W-1:0]   wl_taps,
  output logic               busy,
  output logic [PIPE_W-1:0]  pipe_cnt,
  output logic [DLY_W-1:0]   fine_taps
);
  localparam int unsigned RSV_W = BUS_W - DLY_W;

  logic          sw_fire, hw_cancel, commit;
  load_src_e     src;
  logic [DLY_W-1:0]  raw, ui_cap, quarter;
  logic [PIPE_W-1:0] quo_sat;

  always_comb begin
    wr_ready  = 1'b1;
    sw_fire   = wr_valid && wr_ready;
    quarter   = tck_taps[DLY_W+1:2];
    if (sw_fire)       src = LD_SW;
    else if (wl_done)  src = LD_WL;
    else if (cal_done) src = LD_CAL;
    else               src = LD_NONE;
    hw_cancel = (src == LD_WL) || (src == LD_CAL);
  end

  wds_settle #(.SETTLE(SETTLE)) u_settle (
    .clk(clk), .rst_n(rst_n), .start(sw_fire), .cancel(hw_cancel),
    .busy(busy), .commit(commit)
  );

  wds_divider #(.DW(DLY_W), .QW(PIPE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(sw_fire),
    .dividend(wr_data[DLY_W-1:0]), .divisor(ui_taps), .quo_sat(quo_sat)
  );

  wds_field #(.DW(DLY_W), .QW(PIPE_W)) u_field (
    .clk(clk), .rst_n(rst_n), .src(src),
    .sw_val(wr_data[DLY_W-1:0]), .ui_in(ui_taps), .wl_val(wl_taps),
    .cal_val(quarter), .commit(commit), .quo_sat(quo_sat),
    .raw(raw), .ui_cap(ui_cap), .fine(fine_taps), .pipe(pipe_cnt)
  );

  always_comb rd_data = {{RSV_W{1'b0}}, (busy ? raw : fine_taps)};
endmodule

// File: rtl/wds_checker.sv
module wds_checker #(
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned DLY_W  = 9,
  parameter int unsigned PIPE_W = 4,
  parameter int unsigned SETTLE = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic [BUS_W-1:0]   wr_data,
  input logic [BUS_W-1:0]   rd_data,
  input logic               cal_done,
  input logic [DLY_W+1:0]   tck_taps,
  input logic               wl_done,
  input logic               busy,
  input logic [PIPE_W-1:0]  pipe_cnt,
  input logic [DLY_W-1:0]   fine_taps,
  input logic [DLY_W-1:0]   ui_cap
);
  localparam int unsigned WW = $clog2(SETTLE + 3);
  localparam logic [PIPE_W-1:0] PMAX = '1;

  logic [WW-1:0] win_q;
  logic          hw_pulse;
  always_comb hw_pulse = cal_done || wl_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    win_q <= '0;
    else if (wr_valid && wr_ready) win_q <= WW'(1);
    else if (busy)                 win_q <= win_q + 1'b1;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BUS_W-1:DLY_W] == '0 && tck_taps == tck_taps); // R2

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready); // R3

  AST_RAW_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> busy && rd_data[DLY_W-1:0] == $past(wr_data[DLY_W-1:0])); // R3

  AST_FINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$past(hw_pulse) |-> $stable(fine_taps) && $stable(pipe_cnt)); // R3

  AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(hw_pulse) |-> win_q == WW'(SETTLE + 1)); // R4

  AST_RESID_BELOW_UI: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(hw_pulse) && ui_cap != '0 && pipe_cnt != PMAX |->
      fine_taps < ui_cap && rd_data[DLY_W-1:0] == fine_taps); // R5

  AST_UI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(hw_pulse) && ui_cap == '0 |-> pipe_cnt == '0); // R7

  AST_HW_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    hw_pulse && !wr_valid |=> !busy && pipe_cnt == '0); // R9
endmodule

bind wdly_split_reg wds_checker #(
  .BUS_W(BUS_W), .DLY_W(DLY_W), .PIPE_W(PIPE_W), .SETTLE(SETTLE)
) u_wds_checker (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_data(wr_data), .rd_data(rd_data), .cal_done(cal_done),
  .tck_taps(tck_taps), .wl_done(wl_done), .busy(busy),
  .pipe_cnt(pipe_cnt), .fine_taps(fine_taps), .ui_cap(ui_cap)
);

// File: tb/test_wdly_split_reg.sv
module test_wdly_split_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [8:0]  ui_taps = '0;
  logic        cal_done = 1'b0;
  logic [10:0] tck_taps = '0;
  logic        wl_done = 1'b0;
  logic [8:0]  wl_taps = '0;
  logic        busy;
  logic [3:0]  pipe_cnt;
  logic [8:0]  fine_taps;

  int total = 0;
  int bad = 0;
  bit timed_out = 1'b0;

  always #10 clk = ~clk;

  wdly_split_reg i_wdly_split_reg (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_data(rd_data), .ui_taps(ui_taps),
    .cal_done(cal_done), .tck_taps(tck_taps), .wl_done(wl_done),
    .wl_taps(wl_taps), .busy(busy), .pipe_cnt(pipe_cnt), .fine_taps(fine_taps)
  );

  // total[30:22], ui[21:13], pipe[12:9], resid[8:0]
  localparam int NV = 9;
  localparam logic [30:0] VEC [NV] = '{
    {9'd100, 9'd32,  4'd3,  9'd4},
    {9'd31,  9'd32,  4'd0,  9'd31},
    {9'd64,  9'd32,  4'd2,  9'd0},
    {9'd200, 9'd0,   4'd0,  9'd200},
    {9'd511, 9'd40,  4'd12, 9'd31},
    {9'd300, 9'd16,  4'd15, 9'd60},
    {9'd511, 9'd511, 4'd1,  9'd0},
    {9'd0,   9'd10,  4'd0,  9'd0},
    {9'd255, 9'd17,  4'd15, 9'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, input logic [8:0] ui);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; ui_taps = ui;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #4000000;
    timed_out = 1'b1;
  end

  initial begin
    logic [8:0] t, u, r;
    logic [3:0] p;
    fork
      begin
        idle(3);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 pipe", {28'd0, pipe_cnt}, 0);
        chk("R1 fine", {23'd0, fine_taps}, 0);
        chk("R1 busy", {31'd0, busy}, 0);
        rst_n = 1'b1;
        idle(1);
        chk("R3 ready", {31'd0, wr_ready}, 1);

        for (int k = 0; k < NV; k++) begin
          t = VEC[k][30:22]; u = VEC[k][21:13]; p = VEC[k][12:9]; r = VEC[k][8:0];
          wr({23'd0, t}, u);
          chk("R3 busy open", {31'd0, busy}, 1);
          chk("R3 raw read", rd_data, {23'd0, t});
          idle(19);
          chk("R3 busy at 19", {31'd0, busy}, 1);
          idle(1);
          chk("R3 busy closed", {31'd0, busy}, 0);
          chk("R4 R7 R8 pipe", {28'd0, pipe_cnt}, {28'd0, p});
          chk("R4 R7 R8 fine", {23'd0, fine_taps}, {23'd0, r});
          chk("R5 readback", rd_data, {23'd0, r});
        end

        // R2: upper bits written as ones are ignored
        wr(32'hFFFF_FE05, 9'd0);
        chk("R2 upper zero busy", rd_data, 32'h5);
        idle(20);
        chk("R2 upper zero", rd_data, 32'h5);
        chk("R2 pipe", {28'd0, pipe_cnt}, 0);

        // R6: restart
        wr(32'd100, 9'd32);
        idle(9);
        wr(32'd50, 9'd32);
        idle(19);
        chk("R6 still busy", {31'd0, busy}, 1);
        chk("R6 old fine kept", {23'd0, fine_taps}, 5);
        idle(1);
        chk("R6 busy done", {31'd0, busy}, 0);
        chk("R6 pipe", {28'd0, pipe_cnt}, 1);
        chk("R6 fine", {23'd0, fine_taps}, 18);

        // R9: calibration load cancels pending conversion
        wr(32'd300, 9'd20);
        idle(5);
        @(negedge clk); cal_done = 1'b1; tck_taps = 11'd203;
        @(negedge clk); cal_done = 1'b0;
        chk("R9 busy cleared", {31'd0, busy}, 0);
        chk("R9 fine quarter", {23'd0, fine_taps}, 50);
        chk("R9 pipe zero", {28'd0, pipe_cnt}, 0);
        idle(25);
        chk("R9 no late commit", rd_data, 50);

        // R10: leveling load, and priority
        @(negedge clk); wl_done = 1'b1; cal_done = 1'b1; wl_taps = 9'd77;
        @(negedge clk); wl_done = 1'b0; cal_done = 1'b0;
        chk("R10 wl over cal", {23'd0, fine_taps}, 77);
        @(negedge clk); wl_done = 1'b1; wr_valid = 1'b1; wr_data = 32'd40; ui_taps = 9'd16;
        @(negedge clk); wl_done = 1'b0; wr_valid = 1'b0;
        chk("R10 sw over wl busy", {31'd0, busy}, 1);
        chk("R10 fine held", {23'd0, fine_taps}, 77);
        idle(20);
        chk("R10 sw result pipe", {28'd0, pipe_cnt}, 2);
        chk("R10 sw result fine", {23'd0, fine_taps}, 8);
      end
      begin
        wait (timed_out);
      end
    join_any
    if (timed_out) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule